// File: doc/BRIEF.md
# Integer Execute Unit with Field Decode

This block is the combinational execute step of a 32-bit integer pipeline. It receives one raw instruction word together with the values already read for its two source registers. It splits the word into opcode, register, shift-amount, function and immediate fields, then computes the result in a single pass with no internal state. It also drives the index of the destination register and a write strobe for the register file.

Two instruction shapes are handled. In register-register words (opcode 0) the function field selects the operation and the result targets the rd field. In immediate words the opcode itself selects the operation and the result targets the rt field. Every 16-bit immediate is sign-extended before use, and that includes the logical and unsigned forms. The block covers additions, subtractions, bitwise logic, signed and unsigned compare-to-flag, fixed and register-controlled shifts, and upper-immediate loading. Memory access, control flow, multiply/divide and overflow trapping are handled elsewhere.

Top module: `int_exec_unit`

## Requirements
- R1: With opcode 0, function 0x20 or 0x21 gives src_a + src_b and function 0x22 or 0x23 gives src_a - src_b, both modulo 2^32, written to rd (instr[15:11]).
- R2: With opcode 0, function 0x24, 0x25 and 0x26 give the bitwise AND, OR and XOR of src_a and src_b, written to rd.
- R3: With opcode 0, function 0x2A writes 1 when src_a < src_b as signed values and 0 otherwise, and function 0x2B does the same as an unsigned comparison; bits 31:1 of the result are zero.
- R4: With opcode 0, functions 0x00, 0x02 and 0x03 shift src_b left, logically right and arithmetically right by instr[10:6]. The arithmetic right shift replicates bit 31 and the other two fill with zeros.
- R5: With opcode 0, function 0x04 shifts src_b left and function 0x06 shifts it logically right by src_a[4:0]; bits 31:5 of src_a have no effect.
- R6: Opcodes 0x08 and 0x09 give src_a plus the sign-extended instr[15:0]. Opcodes 0x0A and 0x0B compare src_a against the sign-extended immediate, signed and unsigned respectively, giving 1 or 0. All four write to rt (instr[20:16]).
- R7: Opcodes 0x0C, 0x0D and 0x0E give the AND, OR and XOR of src_a with the sign-extended instr[15:0], written to rt.
- R8: Opcode 0x0F produces instr[15:0] in bits 31:16 and zeros in bits 15:0, written to rt, independent of src_a and of the rs field.
- R9: When the destination index is 0, dst_we is low and res and dst_idx are 0; the all-zero instruction word thus has no effect.
- R10: An opcode outside {0x00, 0x08..0x0F}, or a function code outside the set of R1..R5 under opcode 0, drives dst_we low with res and dst_idx at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Raw instruction word |
| src_a | input | 32 | Value of the register named by instr[25:21] |
| src_b | input | 32 | Value of the register named by instr[20:16] |
| res | output | 32 | Computed result; zero when no write is made |
| dst_idx | output | 5 | Destination register index; zero when no write is made |
| dst_we | output | 1 | Register-file write strobe |

## Verification
The bench builds the unit at its default 32-bit data width and 5-bit register index, which match the fixed instruction format. At that width the five shifter stages cover every amount from 0 to 31, so amounts 0, 1 and 31 can be driven on negative operands. The sign-extension boundary 0x7FFF/0x8000/0xFFFF can be driven on both the logical and the unsigned-compare immediates. The 32-bit wrap of add and subtract can also be reached. Random words then sweep every legal code and many illegal ones against a behavioural model.

// File: rtl/exu_pkg.sv
// exu_pkg: shared widths, field codes and control types for the integer
// execute unit. Assumes the fixed 32-bit instruction layout.
package exu_pkg;

    localparam int XLEN   = 32;
    localparam int REG_AW = 5;
    localparam int OPC_W  = 6;
    localparam int FN_W   = 6;
    localparam int IMM_W  = 16;
    localparam int SH_W   = $clog2(XLEN);

    // opcode values
    localparam logic [OPC_W-1:0] OPC_REG   = 6'h00;
    localparam logic [OPC_W-1:0] OPC_ADDI  = 6'h08;
    localparam logic [OPC_W-1:0] OPC_ADDIU = 6'h09;
    localparam logic [OPC_W-1:0] OPC_SLTI  = 6'h0A;
    localparam logic [OPC_W-1:0] OPC_SLTIU = 6'h0B;
    localparam logic [OPC_W-1:0] OPC_ANDI  = 6'h0C;
    localparam logic [OPC_W-1:0] OPC_ORI   = 6'h0D;
    localparam logic [OPC_W-1:0] OPC_XORI  = 6'h0E;
    localparam logic [OPC_W-1:0] OPC_LUI   = 6'h0F;

    // function values under OPC_REG
    localparam logic [FN_W-1:0] FN_SLL  = 6'h00;
    localparam logic [FN_W-1:0] FN_SRL  = 6'h02;
    localparam logic [FN_W-1:0] FN_SRA  = 6'h03;
    localparam logic [FN_W-1:0] FN_SLLV = 6'h04;
    localparam logic [FN_W-1:0] FN_SRLV = 6'h06;
    localparam logic [FN_W-1:0] FN_ADD  = 6'h20;
    localparam logic [FN_W-1:0] FN_ADDU = 6'h21;
    localparam logic [FN_W-1:0] FN_SUB  = 6'h22;
    localparam logic [FN_W-1:0] FN_SUBU = 6'h23;
    localparam logic [FN_W-1:0] FN_AND  = 6'h24;
    localparam logic [FN_W-1:0] FN_OR   = 6'h25;
    localparam logic [FN_W-1:0] FN_XOR  = 6'h26;
    localparam logic [FN_W-1:0] FN_SLT  = 6'h2A;
    localparam logic [FN_W-1:0] FN_SLTU = 6'h2B;

    typedef enum logic [3:0] {
        OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR,
        OP_SLT, OP_SLTU, OP_SLL, OP_SRL, OP_SRA, OP_LUI, OP_NONE
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LEFT, SH_LRIGHT, SH_ARIGHT
    } shift_kind_e;

    typedef struct packed {
        alu_op_e op;        // operation for the datapath
        logic    use_imm;   // second operand is the extended immediate
        logic    var_sh;    // shift amount comes from src_a
        logic    dst_rd;    // destination is rd rather than rt
        logic    legal;     // code recognised
    } exu_ctrl_t;

endpackage

// File: rtl/exu_decode.sv
// exu_decode: maps opcode and function fields to datapath control.
// Assumes nothing about operand values; purely combinational.
module exu_decode
    import exu_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    input  logic [FN_W-1:0]  funct,
    output exu_ctrl_t        ctrl
);

    // Decode one instruction class and operation per word.
    always_comb begin
        ctrl = '{op: OP_NONE, use_imm: 1'b0, var_sh: 1'b0, dst_rd: 1'b0, legal: 1'b0};
        if (opcode == OPC_REG) begin
            ctrl.dst_rd = 1'b1;
            ctrl.legal  = 1'b1;
            case (funct)
                FN_ADD, FN_ADDU: ctrl.op = OP_ADD;
                FN_SUB, FN_SUBU: ctrl.op = OP_SUB;
                FN_AND:          ctrl.op = OP_AND;
                FN_OR:           ctrl.op = OP_OR;
                FN_XOR:          ctrl.op = OP_XOR;
                FN_SLT:          ctrl.op = OP_SLT;
                FN_SLTU:         ctrl.op = OP_SLTU;
                FN_SLL:          ctrl.op = OP_SLL;
                FN_SRL:          ctrl.op = OP_SRL;
                FN_SRA:          ctrl.op = OP_SRA;
                FN_SLLV: begin
                    ctrl.op     = OP_SLL;
                    ctrl.var_sh = 1'b1;
                end
                FN_SRLV: begin
                    ctrl.op     = OP_SRL;
                    ctrl.var_sh = 1'b1;
                end
                default: ctrl.legal = 1'b0;
            endcase
        end else begin
            ctrl.use_imm = 1'b1;
            ctrl.legal   = 1'b1;
            case (opcode)
                OPC_ADDI, OPC_ADDIU: ctrl.op = OP_ADD;
                OPC_SLTI:            ctrl.op = OP_SLT;
                OPC_SLTIU:           ctrl.op = OP_SLTU;
                OPC_ANDI:            ctrl.op = OP_AND;
                OPC_ORI:             ctrl.op = OP_OR;
                OPC_XORI:            ctrl.op = OP_XOR;
                OPC_LUI:             ctrl.op = OP_LUI;
                default:             ctrl.legal = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/exu_shift.sv
// exu_shift: logarithmic barrel shifter, one stage per amount bit.
// Assumes W is a power of two so that AW bits cover every amount.
module exu_shift
    import exu_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int AW = $clog2(W)
) (
    input  logic [W-1:0]  value,
    input  logic [AW-1:0] amount,
    input  shift_kind_e   kind,
    output logic [W-1:0]  result
);

    logic [W-1:0] stg [0:AW];

    assign stg[0] = value;

    for (genvar k = 0; k < AW; k++) begin : g_stage
        localparam int DIST = 2 ** k;
        logic signed [W-1:0] ar;
        // Arithmetic variant kept in its own signed signal.
        assign ar = $signed(stg[k]) >>> DIST;
        // Apply this stage's power-of-two step when its amount bit is set.
        assign stg[k+1] = !amount[k]          ? stg[k] :
                          (kind == SH_LEFT)   ? (stg[k] << DIST) :
                          (kind == SH_LRIGHT) ? (stg[k] >> DIST) :
                                                W'(ar);
    end

    assign result = stg[AW];

    // Fill-bit checks on the final stage against the raw input.
    always_comb begin
        if (amount != '0) begin
            if (kind == SH_LEFT)
                p_left_zero_fill_r4: assert (result[0] == 1'b0)
                    else $error("left shift filled a one");
            if (kind == SH_LRIGHT)
                p_lright_zero_fill_r4: assert (result[W-1] == 1'b0)
                    else $error("logical right shift filled a one");
            if (kind == SH_ARIGHT)
                p_aright_sign_fill_r4: assert (result[W-1] == value[W-1])
                    else $error("arithmetic right shift lost the sign");
        end
    end

endmodule

// File: rtl/exu_alu.sv
// exu_alu: arithmetic, logic, compare, shift and upper-immediate datapath.
// Assumes operand b is already selected (register or extended immediate).
module exu_alu
    import exu_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int AW = $clog2(W)
) (
    input  alu_op_e       op,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    input  logic [AW-1:0] shamt,
    output logic [W-1:0]  y
);

    localparam int HALF = W / 2;

    shift_kind_e  sh_kind;
    logic [W-1:0] sh_out;

    // Pick the shifter direction from the operation.
    always_comb begin
        case (op)
            OP_SRL:  sh_kind = SH_LRIGHT;
            OP_SRA:  sh_kind = SH_ARIGHT;
            default: sh_kind = SH_LEFT;
        endcase
    end

    exu_shift #(.W(W), .AW(AW)) u_shift (
        .value  (b),
        .amount (shamt),
        .kind   (sh_kind),
        .result (sh_out)
    );

    // Produce the selected operation's result.
    always_comb begin
        case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_SLT:  y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            OP_SLTU: y = {{(W-1){1'b0}}, (a < b)};
            OP_SLL, OP_SRL, OP_SRA: y = sh_out;
            OP_LUI:  y = {b[HALF-1:0], {HALF{1'b0}}};
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/int_exec_unit.sv
// int_exec_unit: combinational execute step. Splits the word into fields,
// decodes, extends the immediate, runs the datapath and gates the write.
// Assumes src_a/src_b already hold the rs/rt register values.
module int_exec_unit
    import exu_pkg::*;
(
    input  logic [XLEN-1:0]   instr,
    input  logic [XLEN-1:0]   src_a,
    input  logic [XLEN-1:0]   src_b,
    output logic [XLEN-1:0]   res,
    output logic [REG_AW-1:0] dst_idx,
    output logic              dst_we
);

    logic [OPC_W-1:0]  opcode;
    logic [FN_W-1:0]   funct;
    logic [REG_AW-1:0] f_rt, f_rd;
    logic [REG_AW-1:0] unused_rs;
    logic [SH_W-1:0]   f_sh;
    logic [XLEN-1:0]   imm_ext;
    logic [XLEN-1:0]   opnd_b;
    logic [SH_W-1:0]   shamt;
    logic [XLEN-1:0]   alu_y;
    logic [REG_AW-1:0] tgt;
    exu_ctrl_t         ctrl;

    assign opcode    = instr[XLEN-1 -: OPC_W];
    assign unused_rs = instr[25:21];
    assign f_rt      = instr[20:16];
    assign f_rd      = instr[15:11];
    assign f_sh      = instr[6 +: SH_W];
    assign funct     = instr[FN_W-1:0];
    assign imm_ext   = {{(XLEN-IMM_W){instr[IMM_W-1]}}, instr[IMM_W-1:0]};

    exu_decode u_decode (
        .opcode (opcode),
        .funct  (funct),
        .ctrl   (ctrl)
    );

    // Choose second operand and shift amount source.
    always_comb begin
        opnd_b = ctrl.use_imm ? imm_ext : src_b;
        shamt  = ctrl.var_sh  ? src_a[SH_W-1:0] : f_sh;
    end

    exu_alu #(.W(XLEN), .AW(SH_W)) u_alu (
        .op    (ctrl.op),
        .a     (src_a),
        .b     (opnd_b),
        .shamt (shamt),
        .y     (alu_y)
    );

    // Gate the write on legality and a non-zero destination.
    always_comb begin
        tgt     = ctrl.dst_rd ? f_rd : f_rt;
        dst_we  = ctrl.legal && (tgt != '0);
        res     = dst_we ? alu_y : '0;
        dst_idx = dst_we ? tgt   : '0;
    end

    // Output-level properties tied to the instruction word.
    always_comb begin
        if (instr == '0)
            p_nop_silent_r9: assert (!dst_we)
                else $error("zero word produced a write");
        if (opcode == OPC_LUI && dst_we)
            p_lui_low_clear_r8: assert (res[IMM_W-1:0] == '0)
                else $error("upper-immediate low half not zero");
        if (opcode == OPC_REG && (funct == FN_SLT || funct == FN_SLTU) && dst_we)
            p_slt_flag_only_r3: assert (res[XLEN-1:1] == '0)
                else $error("compare result wider than one bit");
        if (opcode != OPC_REG && opcode[OPC_W-1:3] != 3'b001)
            p_bad_opcode_quiet_r10: assert (!dst_we && res == '0)
                else $error("unknown opcode produced a write");
    end

endmodule

// File: tb/int_exec_unit_tb.sv
`timescale 1ns/1ps
module int_exec_unit_tb;

    logic        clk = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [31:0] res;
    logic [4:0]  dst_idx;
    logic        dst_we;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    int_exec_unit u_dut (
        .instr   (instr),
        .src_a   (src_a),
        .src_b   (src_b),
        .res     (res),
        .dst_idx (dst_idx),
        .dst_we  (dst_we)
    );

    // Behavioural model written from the requirements.
    task automatic model(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b,
                         output logic [31:0] r, output logic [4:0] d, output logic we,
                         output string tag);
        logic [5:0]  opc = w[31:26];
        logic [5:0]  fn  = w[5:0];
        logic [4:0]  sh  = w[10:6];
        logic [31:0] imm = {{16{w[15]}}, w[15:0]};
        bit ok = 1;
        r = 0;
        if (opc == 0) begin
            d = w[15:11];
            case (fn)
                6'h20, 6'h21: begin r = a + b; tag = "R1"; end
                6'h22, 6'h23: begin r = a - b; tag = "R1"; end
                6'h24: begin r = a & b; tag = "R2"; end
                6'h25: begin r = a | b; tag = "R2"; end
                6'h26: begin r = a ^ b; tag = "R2"; end
                6'h2A: begin r = ($signed(a) < $signed(b)) ? 1 : 0; tag = "R3"; end
                6'h2B: begin r = (a < b) ? 1 : 0; tag = "R3"; end
                6'h00: begin r = b << sh; tag = "R4"; end
                6'h02: begin r = b >> sh; tag = "R4"; end
                6'h03: begin r = 32'($signed(b) >>> sh); tag = "R4"; end
                6'h04: begin r = b << a[4:0]; tag = "R5"; end
                6'h06: begin r = b >> a[4:0]; tag = "R5"; end
                default: begin ok = 0; tag = "R10"; end
            endcase
        end else begin
            d = w[20:16];
            case (opc)
                6'h08, 6'h09: begin r = a + imm; tag = "R6"; end
                6'h0A: begin r = ($signed(a) < $signed(imm)) ? 1 : 0; tag = "R6"; end
                6'h0B: begin r = (a < imm) ? 1 : 0; tag = "R6"; end
                6'h0C: begin r = a & imm; tag = "R7"; end
                6'h0D: begin r = a | imm; tag = "R7"; end
                6'h0E: begin r = a ^ imm; tag = "R7"; end
                6'h0F: begin r = {w[15:0], 16'h0}; tag = "R8"; end
                default: begin ok = 0; tag = "R10"; end
            endcase
        end
        if (ok && d == 0) tag = "R9";
        we = ok && (d != 0);
        if (!we) begin
            r = 0;
            d = 0;
        end
    endtask

    // Drive one vector after a rising edge, compare at the falling edge.
    task automatic apply(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] er;
        logic [4:0]  ed;
        logic        ew;
        string       tag;
        @(posedge clk);
        instr = w;
        src_a = a;
        src_b = b;
        model(w, a, b, er, ed, ew, tag);
        @(negedge clk);
        n_checks++;
        if (res !== er || dst_idx !== ed || dst_we !== ew) begin
            n_fails++;
            $display("FAIL %s instr=%h a=%h b=%h: got res=%h idx=%0d we=%b, expected res=%h idx=%0d we=%b",
                     tag, w, a, b, res, dst_idx, dst_we, er, ed, ew);
        end
    endtask

    function automatic logic [31:0] rt_word(input logic [5:0] fn, input logic [4:0] rd,
                                            input logic [4:0] sh);
        return {6'h00, 5'd3, 5'd4, rd, sh, fn};
    endfunction

    function automatic logic [31:0] im_word(input logic [5:0] opc, input logic [4:0] rt,
                                            input logic [15:0] imm);
        return {opc, 5'd9, rt, imm};
    endfunction

    initial begin
        logic [5:0] rfn [14] = '{6'h20, 6'h21, 6'h22, 6'h23, 6'h24, 6'h25, 6'h26,
                                 6'h2A, 6'h2B, 6'h00, 6'h02, 6'h03, 6'h04, 6'h06};
        // initial state: zero word, no write (R9)
        apply(32'h0, 32'hFFFF_FFFF, 32'h1234_5678);
        // R1 wrap-around add and subtract
        apply(rt_word(6'h20, 5'd7, 5'd0), 32'h7FFF_FFFF, 32'h1);
        apply(rt_word(6'h21, 5'd7, 5'd0), 32'hFFFF_FFFF, 32'h2);
        apply(rt_word(6'h23, 5'd8, 5'd0), 32'h0, 32'h1);
        // R2 logic
        apply(rt_word(6'h26, 5'd2, 5'd0), 32'hF0F0_1234, 32'h0FF0_FFFF);
        // R3 signed vs unsigned compare on the same operands
        apply(rt_word(6'h2A, 5'd5, 5'd0), 32'h8000_0000, 32'h1);
        apply(rt_word(6'h2B, 5'd5, 5'd0), 32'h8000_0000, 32'h1);
        apply(rt_word(6'h2A, 5'd5, 5'd0), 32'h5, 32'h5);
        // R4 fixed shifts at 0, 1, 31
        apply(rt_word(6'h03, 5'd6, 5'd31), 32'h0, 32'h8000_0000);
        apply(rt_word(6'h02, 5'd6, 5'd31), 32'h0, 32'h8000_0000);
        apply(rt_word(6'h03, 5'd6, 5'd1), 32'h0, 32'h7FFF_FFFE);
        apply(rt_word(6'h00, 5'd6, 5'd0), 32'h0, 32'hDEAD_BEEF);
        // R5 variable shifts use only src_a[4:0]
        apply(rt_word(6'h04, 5'd9, 5'd0), 32'hFFFF_FFE5, 32'h0000_0003);
        apply(rt_word(6'h06, 5'd9, 5'd17), 32'h0000_0020, 32'h8000_0001);
        // R6 immediate arithmetic and compares
        apply(im_word(6'h08, 5'd10, 16'hFFFF), 32'h0, 32'h0);
        apply(im_word(6'h0B, 5'd10, 16'hFFFF), 32'hFFFF_FFFE, 32'h0);
        apply(im_word(6'h0A, 5'd10, 16'h8000), 32'hFFFF_8001, 32'h0);
        // R7 logical immediates are sign-extended
        apply(im_word(6'h0C, 5'd11, 16'h8000), 32'hFFFF_FFFF, 32'h0);
        apply(im_word(6'h0D, 5'd11, 16'h7FFF), 32'h1234_0000, 32'h0);
        // R8 upper immediate ignores src_a
        apply(im_word(6'h0F, 5'd12, 16'hABCD), 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        // R9 destination 0 suppressed for both shapes
        apply(rt_word(6'h20, 5'd0, 5'd0), 32'h1, 32'h1);
        apply(im_word(6'h0D, 5'd0, 16'h1), 32'h1, 32'h0);
        // R10 unknown codes
        apply(rt_word(6'h07, 5'd4, 5'd2), 32'h1, 32'h8000_0000);
        apply(im_word(6'h02, 5'd4, 16'h1), 32'h1, 32'h1);
        apply(im_word(6'h23, 5'd4, 16'h1), 32'h1, 32'h1);
        // random sweep over legal and illegal words
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] w = $urandom;
            int sel = $urandom_range(0, 9);
            if (sel < 5)      w[31:26] = 6'h00;
            if (sel < 4)      w[5:0] = rfn[$urandom_range(0, 13)];
            else if (sel < 8) w[31:26] = 6'(8 + $urandom_range(0, 7));
            apply(w, $urandom, $urandom);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired after %0d checks", n_checks);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule